// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block drives the two synchronous rectifier gates of a phase-shifted full-bridge converter with a current-doubler output. Its inputs are the four primary bridge drives. Each rectifier gate is formed from the overlap of one diagonal pair of bridge legs. The first pair is the high-side A drive with the low-side D drive. The second pair is the high-side B drive with the low-side C drive. Rectifier 1 belongs to the first pair and rectifier 2 to the second.

A 2-bit request selects one of three drive policies:
- Off: both gates stay low, so the stage runs as a diode current doubler.
- Ideal-diode: a gate conducts only while its own pair overlaps.
- Complementary: a gate conducts except while the other pair overlaps.

A new request takes effect only on a period-start strobe. This lets the control loop change policy at any time without cutting a pulse in the middle. Each gate leaves through a register that enforces a programmable minimum on-time, so short overlaps never reach the gate driver. A separate kill input drops both gates within one clock.

The block carries no data stream, so it has no valid/ready handshake. All pins are plain control levels, sampled on the rising clock edge.

Top module: `sr_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, both gates are low. After reset the active policy is Off until a strobe loads a new one.
- R2: At a clock edge where `per_strobe` is high, the `mode_req` value becomes the active policy. At all other edges the active policy is unchanged. The code 2'b01 selects ideal-diode, the code 2'b10 selects complementary, and the codes 2'b00 and 2'b11 select Off.
- R3: When the policy active at edge k is Off, both gates are low after edge k.
- R4: Under ideal-diode, a gate is demanded at an edge only when both drives of its own pair are high at that edge. The pair for `rect1_g` is `br_a_hi`&`br_d_lo`, and the pair for `rect2_g` is `br_b_hi`&`br_c_lo`.
- R5: Under complementary, a gate is demanded at an edge unless both drives of the opposite pair are high at that edge. The opposite pair for `rect1_g` is B&C, and for `rect2_g` it is A&D.
- R6: Demand is counted in consecutive clock edges. A demand run of L edges with L >= N (N = `min_on`, where 0 acts as 1) raises the gate after the N-th edge of the run. The gate then stays high for L-N+1 cycles. A run with L < N leaves the gate low throughout.
- R7: At any edge where `gate_off` is high, both gates go low after that edge and the on-time counters restart. The active policy is not altered.
- R8: The gates are recomputed at every edge from the policy active before that edge and from the present bridge inputs. A policy loaded at edge k therefore governs the gate values from edge k+1 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_a_hi | input | 1 | Bridge high-side A drive |
| br_b_hi | input | 1 | Bridge high-side B drive |
| br_c_lo | input | 1 | Bridge low-side C drive |
| br_d_lo | input | 1 | Bridge low-side D drive |
| per_strobe | input | 1 | Period start; loads the requested policy |
| mode_req | input | 2 | Requested policy code |
| gate_off | input | 1 | Forces both gates low, active high |
| min_on | input | CNT_W | Minimum on-time in clock cycles |
| rect1_g | output | 1 | Rectifier 1 gate |
| rect2_g | output | 1 | Rectifier 2 gate |

## Verification
The active policy is not visible at the ports, so a corrupted policy register shows up as a wrong gate level on the first edge where the bridge pattern differs between the two policies. The random bridge stimulus makes such patterns appear within a few cycles. A stuck or miscounting on-time counter shows up as a gate that rises one or more cycles too early or too late, or as a runt that should have been filtered, within one demand run. Leakage of a request between strobes shows up at the first overlap after the unstrobed request.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    SRM_OFF   = 2'b00,
    SRM_DIODE = 2'b01,
    SRM_COMPL = 2'b10
  } srm_e;

  localparam int unsigned SR_CH = 2;

  // reserved code folds to Off
  function automatic srm_e srm_decode(input logic [1:0] code);
    case (code)
      2'b01:   return SRM_DIODE;
      2'b10:   return SRM_COMPL;
      default: return SRM_OFF;
    endcase
  endfunction
endpackage

// File: rtl/srg_mode_reg.sv
module srg_mode_reg
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       per_strobe,
  input  logic [1:0] mode_req,
  output srm_e       act_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_mode <= SRM_OFF;
    else if (per_strobe) act_mode <= srm_decode(mode_req);
  end
endmodule

// File: rtl/srg_demand.sv
module srg_demand
  import srg_pkg::*;
(
  input  srm_e             act_mode,
  input  logic [SR_CH-1:0] pair_ovl,
  output logic [SR_CH-1:0] dem
);
  for (genvar ch = 0; ch < SR_CH; ch++) begin : g_ch
    localparam int unsigned OPP = SR_CH - 1 - ch;
    always_comb begin
      case (act_mode)
        SRM_DIODE: dem[ch] = pair_ovl[ch];
        SRM_COMPL: dem[ch] = ~pair_ovl[OPP];
        default:   dem[ch] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/srg_min_on.sv
module srg_min_on #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             dem,
  input  logic [CNT_W-1:0] min_on,
  output logic             gate
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nx;

  always_comb begin
    if (!dem)                run_nx = '0;
    else if (run_q == CNT_MAX) run_nx = run_q;
    else                     run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      gate  <= 1'b0;
    end else if (kill) begin
      run_q <= '0;
      gate  <= 1'b0;
    end else begin
      run_q <= run_nx;
      gate  <= dem && (run_nx >= min_on);
    end
  end
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import srg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_a_hi,
  input  logic             br_b_hi,
  input  logic             br_c_lo,
  input  logic             br_d_lo,
  input  logic             per_strobe,
  input  logic [1:0]       mode_req,
  input  logic             gate_off,
  input  logic [CNT_W-1:0] min_on,
  output logic             rect1_g,
  output logic             rect2_g
);
  srm_e             act_mode;
  logic [SR_CH-1:0] pair_ovl;
  logic [SR_CH-1:0] dem;
  logic [SR_CH-1:0] gates;

  assign pair_ovl[0] = br_a_hi & br_d_lo;
  assign pair_ovl[1] = br_b_hi & br_c_lo;

  srg_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_strobe (per_strobe),
    .mode_req   (mode_req),
    .act_mode   (act_mode)
  );

  srg_demand u_dem (
    .act_mode (act_mode),
    .pair_ovl (pair_ovl),
    .dem      (dem)
  );

  for (genvar ch = 0; ch < SR_CH; ch++) begin : g_out
    srg_min_on #(.CNT_W(CNT_W)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (gate_off),
      .dem    (dem[ch]),
      .min_on (min_on),
      .gate   (gates[ch])
    );
  end

  assign rect1_g = gates[0];
  assign rect2_g = gates[1];
endmodule

// File: rtl/sr_gate_ctrl_chk.sv
module sr_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] act_mode,
  input logic       br_a_hi,
  input logic       br_b_hi,
  input logic       br_c_lo,
  input logic       br_d_lo,
  input logic       per_strobe,
  input logic       gate_off,
  input logic       rect1_g,
  input logic       rect2_g
);
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_low_chk: assert (!rect1_g && !rect2_g);
    end
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !per_strobe |=> $stable(act_mode));

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b00) |=> (!rect1_g && !rect2_g));

  // R4
  diode_r1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b01 && !(br_a_hi && br_d_lo)) |=> !rect1_g);

  // R4
  diode_r2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b01 && !(br_b_hi && br_c_lo)) |=> !rect2_g);

  // R5
  compl_r1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b10 && br_b_hi && br_c_lo) |=> !rect1_g);

  // R5
  compl_r2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b10 && br_a_hi && br_d_lo) |=> !rect2_g);

  // R7
  kill_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> (!rect1_g && !rect2_g));
endmodule

bind sr_gate_ctrl sr_gate_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .act_mode   (act_mode),
  .br_a_hi    (br_a_hi),
  .br_b_hi    (br_b_hi),
  .br_c_lo    (br_c_lo),
  .br_d_lo    (br_d_lo),
  .per_strobe (per_strobe),
  .gate_off   (gate_off),
  .rect1_g    (rect1_g),
  .rect2_g    (rect2_g)
);

// File: tb/sr_gate_ctrl_tb_top.sv
module sr_gate_ctrl_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 0, b = 0, c = 0, d = 0;
  logic ps = 0, off = 0;
  logic [1:0] mreq = 2'b00;
  logic [CNT_W-1:0] mon = 8'd1;
  logic g1, g2;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  int m_mode = 0;
  int m_cnt[2] = '{0, 0};
  bit m_out[2] = '{0, 0};

  always #5 clk = ~clk;

  sr_gate_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .br_a_hi(a), .br_b_hi(b), .br_c_lo(c), .br_d_lo(d),
    .per_strobe(ps), .mode_req(mreq), .gate_off(off), .min_on(mon),
    .rect1_g(g1), .rect2_g(g2)
  );

  function automatic int code_to_mode(input logic [1:0] cd);
    if (cd == 2'b01) return 1;
    if (cd == 2'b10) return 2;
    return 0;
  endfunction

  function automatic bit want(input int md, input bit own_ovl, input bit opp_ovl);
    if (md == 1) return own_ovl;
    if (md == 2) return !opp_ovl;
    return 1'b0;
  endfunction

  task automatic model_edge();
    bit ov[2];
    bit dm[2];
    int lim;
    ov[0] = a && d;
    ov[1] = b && c;
    lim = (mon == 0) ? 1 : int'(mon);
    for (int ch = 0; ch < 2; ch++) begin
      dm[ch] = want(m_mode, ov[ch], ov[1-ch]);
      if (off) begin
        m_cnt[ch] = 0;
        m_out[ch] = 0;
      end else begin
        m_cnt[ch] = dm[ch] ? ((m_cnt[ch] < 255) ? m_cnt[ch] + 1 : 255) : 0;
        m_out[ch] = dm[ch] && (m_cnt[ch] >= lim);
      end
    end
    if (ps) m_mode = code_to_mode(mreq);
  endtask

  task automatic compare(input string tag);
    n_run++;
    if (g1 !== m_out[0] || g2 !== m_out[1]) begin
      n_fail++;
      $display("FAIL %s: gates actual %b%b expected %b%b at %0t",
               tag, g1, g2, m_out[0], m_out[1], $time);
    end
  endtask

  task automatic step(input bit ia, input bit ib, input bit ic, input bit id,
                      input bit ips, input logic [1:0] imr, input bit ioff,
                      input string tag);
    a = ia; b = ib; c = ic; d = id;
    ps = ips; mreq = imr; off = ioff;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string mode_tag();
    if (off) return "R7";
    if (mon > 1) return "R6";
    if (m_mode == 1) return "R4";
    if (m_mode == 2) return "R5";
    return "R3";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20210611);
    a = 1; b = 1; c = 1; d = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_run++;
    if (g1 !== 1'b0 || g2 !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: gates actual %b%b expected 00", g1, g2);
    end
    rst_n = 1'b1;
    // R1: policy Off after reset, overlaps present
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 2'b10, 0, "R1");

    // R2: request without strobe is not taken
    mon = 8'd1;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, 2'b01, 0, "R2");
    // R2 and R8: strobe loads diode; next edge still Off demand, then diode
    step(1, 0, 0, 1, 1, 2'b01, 0, "R8");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, 2'b00, 0, "R4");
    step(0, 1, 1, 0, 0, 2'b00, 0, "R4");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R4");
    // R2: reserved code gives Off
    step(1, 0, 0, 1, 1, 2'b11, 0, "R2");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 2'b00, 0, "R2");

    // R6: runt suppression in diode policy, min_on = 3
    step(0, 0, 0, 0, 1, 2'b01, 0, "R6");
    mon = 8'd3;
    step(1, 0, 0, 1, 0, 2'b00, 0, "R6");
    step(1, 0, 0, 1, 0, 2'b00, 0, "R6");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R6");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0, 2'b00, 0, "R6");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R6");
    mon = 8'd0;
    step(1, 0, 0, 1, 0, 2'b00, 0, "R6");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R6");
    mon = 8'd1;

    // R5 and R7: complementary, then kill
    step(0, 0, 0, 0, 1, 2'b10, 0, "R5");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 2'b00, 0, "R5");
    step(0, 1, 1, 0, 0, 2'b00, 0, "R5");
    step(1, 0, 0, 1, 0, 2'b00, 0, "R5");
    step(0, 0, 0, 0, 0, 2'b00, 1, "R7");
    step(0, 0, 0, 0, 0, 2'b00, 1, "R7");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R7");

    // R8: switch complementary to diode mid-run
    step(1, 0, 0, 1, 1, 2'b01, 0, "R8");
    step(1, 0, 0, 1, 0, 2'b00, 0, "R8");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R8");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] rm;
      bit rps, roff;
      if ($urandom_range(0, 63) == 0) mon = 8'($urandom_range(0, 5));
      rps  = ($urandom_range(0, 7) == 0);
      roff = ($urandom_range(0, 31) == 0);
      rm   = 2'($urandom_range(0, 3));
      a = 1'($urandom); b = 1'($urandom); c = 1'($urandom); d = 1'($urandom);
      step(a, b, c, d, rps, rm, roff, mode_tag());
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule